// File: doc/BRIEF.md
# Timer Channel Output Stage

This block drives one timer output pin from timer events. The counter and compare logic sit elsewhere. They deliver single-cycle event pulses: a toggle pulse from the channel's own interrupt, a set pulse from the paired master channel and a reset pulse from the slave channel. The stage turns these pulses into a pin level. Every clock edge counts as one count clock, and the reset is synchronous and active-low.

There are two modes. In toggle mode (`mode_i` = 0), every toggle event inverts the stored output state, and the pin follows that state directly. In combination mode (`mode_i` = 1), set and reset events drive the state, which gives PWM. The pin then equals the state XOR an applied polarity bit. That polarity bit is taken from `act_lvl_i` only when an output change happens, or while output is disabled. A set is held back one count clock so that a reset on the same point can win, which makes 0 % and 100 % duty possible.

While output is disabled, events are ignored. Software can load a default level through `sw_wr_i`/`sw_val_i`, and later events start from that level. Software writes are also accepted while output is enabled, but an event in the same cycle takes precedence.

Top module: `timer_out_ctrl`

## Requirements
- R1: One clock edge after `rst_n` is sampled low, `state_o` and `pin_o` are both 0, and the applied polarity is 0.
- R2: With `mode_i`=0 and `out_en_i`=1, each edge that samples `ev_toggle_i`=1 inverts `state_o`. `pin_o` equals `state_o` regardless of `act_lvl_i`, and `ev_set_i`/`ev_reset_i` have no effect.
- R3: With `mode_i`=1, `pin_o` = `state_o` XOR applied polarity. While output is enabled, a new `act_lvl_i` value is loaded into the applied polarity only at an edge with a change condition, so rewriting it alone leaves `pin_o` unchanged.
- R4: With `mode_i`=1 and output enabled, `ev_set_i` sampled at edge t sets `state_o` to 1 at edge t+1 and not at edge t.
- R5: With `mode_i`=1 and output enabled, `ev_reset_i` clears `state_o` at the edge that samples it. If it meets a delayed set at the same edge, the reset wins.
- R6: A software write (`sw_wr_i`=1) loads `sw_val_i` into `state_o` at the next edge. If a hardware change condition occurs at the same edge, the event result is stored instead.
- R7: With `out_en_i`=0, toggle, set and reset events leave `state_o` unchanged. Only software writes alter it, and the applied polarity follows `act_lvl_i` at every edge.
- R8: A level written while output is disabled appears on `pin_o` when output is enabled, and the next toggle event inverts from that level.
- R9: Changing `mode_i`, `act_lvl_i` or `out_en_i` without an event or a software write does not change `state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = toggle mode, 1 = set/reset combination mode |
| act_lvl_i | input | 1 | Requested output polarity for combination mode |
| out_en_i | input | 1 | Output enable; events are ignored while 0 |
| sw_wr_i | input | 1 | Software write strobe for the output value |
| sw_val_i | input | 1 | Value written by software |
| ev_toggle_i | input | 1 | Own-channel event pulse (toggle mode) |
| ev_set_i | input | 1 | Master-channel set pulse (combination mode) |
| ev_reset_i | input | 1 | Slave-channel reset pulse (combination mode) |
| state_o | output | 1 | Stored logical output state |
| pin_o | output | 1 | Timer output pin level |

## Verification
The assertions check the following on every cycle:
- toggle inversion;
- immediate reset and the reset's win over a set;
- the one-edge hold-back of a set;
- the absence of state change while disabled;
- the stability of the pin when only the polarity input moves in combination mode.

Some behaviour can only be shown by the bench scenarios. These cover the contest between a software write and an event in the same cycle, a default level carrying through enable into the next toggle, and the lazily applied polarity becoming visible at a later reset. A behavioural reference model, which holds the deferred sets in a queue, is compared with both outputs on every clock.

// File: rtl/toc_pkg.sv
package toc_pkg;

  typedef enum logic {
    TOC_MODE_TOGGLE = 1'b0,
    TOC_MODE_COMBO  = 1'b1
  } toc_mode_e;

  // Result of a change condition on the logical state.
  function automatic logic toc_event_value(
    input toc_mode_e mode,
    input logic      cur_state,
    input logic      reset_ev,
    input logic      set_fire
  );
    logic v;
    if (mode == TOC_MODE_TOGGLE) begin
      v = ~cur_state;
    end else if (reset_ev) begin
      v = 1'b0;                 // reset dominates a coincident set
    end else if (set_fire) begin
      v = 1'b1;
    end else begin
      v = cur_state;
    end
    return v;
  endfunction

  // Pin level seen outside for a given state and applied polarity.
  function automatic logic toc_pin_level(
    input toc_mode_e mode,
    input logic      cur_state,
    input logic      polarity
  );
    return (mode == TOC_MODE_COMBO) ? (cur_state ^ polarity) : cur_state;
  endfunction

endpackage

// File: rtl/toc_set_delay.sv
module toc_set_delay #(
  parameter int unsigned DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req_i,
  output logic set_fire_o
);
  logic [DELAY-1:0] pipe_q;

  generate
    if (DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= set_req_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[DELAY-2:0], set_req_i};
      end
    end
  endgenerate

  assign set_fire_o = pipe_q[DELAY-1];
endmodule

// File: rtl/toc_cond.sv
module toc_cond
  import toc_pkg::*;
(
  input  toc_mode_e mode_i,
  input  logic      out_en_i,
  input  logic      cur_state_i,
  input  logic      ev_toggle_i,
  input  logic      set_fire_i,
  input  logic      ev_reset_i,
  output logic      chg_o,
  output logic      chg_val_o
);
  logic raw_chg;

  always_comb begin
    if (mode_i == TOC_MODE_COMBO) raw_chg = set_fire_i | ev_reset_i;
    else                          raw_chg = ev_toggle_i;
  end

  assign chg_o     = out_en_i & raw_chg;
  assign chg_val_o = toc_event_value(mode_i, cur_state_i, ev_reset_i, set_fire_i);
endmodule

// File: rtl/toc_level_hold.sv
module toc_level_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en_i,
  input  logic chg_i,
  input  logic act_lvl_i,
  output logic lvl_o
);
  logic lvl_q;

  // Polarity is tracked freely while idle, frozen while running,
  // and refreshed only at an output change condition.
  always_ff @(posedge clk) begin
    if (!rst_n)                 lvl_q <= 1'b0;
    else if (!out_en_i || chg_i) lvl_q <= act_lvl_i;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/toc_state_reg.sv
module toc_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic chg_val_i,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  output logic state_o
);
  logic st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       st_q <= 1'b0;
    else if (chg_i)   st_q <= chg_val_i;   // hardware event beats software
    else if (sw_wr_i) st_q <= sw_val_i;
  end

  assign state_o = st_q;
endmodule

// File: rtl/timer_out_ctrl.sv
module timer_out_ctrl
  import toc_pkg::*;
#(
  parameter int unsigned SET_DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic act_lvl_i,
  input  logic out_en_i,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  input  logic ev_toggle_i,
  input  logic ev_set_i,
  input  logic ev_reset_i,
  output logic state_o,
  output logic pin_o
);
  toc_mode_e mode_w;
  logic      set_req_w;
  logic      set_fire_w;
  logic      chg_w;
  logic      chg_val_w;
  logic      lvl_w;
  logic      st_w;

  assign mode_w    = toc_mode_e'(mode_i);
  assign set_req_w = (mode_w == TOC_MODE_COMBO) & ev_set_i;

  toc_set_delay #(.DELAY(SET_DELAY)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req_i  (set_req_w),
    .set_fire_o (set_fire_w)
  );

  toc_cond u_cond (
    .mode_i      (mode_w),
    .out_en_i    (out_en_i),
    .cur_state_i (st_w),
    .ev_toggle_i (ev_toggle_i),
    .set_fire_i  (set_fire_w),
    .ev_reset_i  (ev_reset_i),
    .chg_o       (chg_w),
    .chg_val_o   (chg_val_w)
  );

  toc_level_hold u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en_i  (out_en_i),
    .chg_i     (chg_w),
    .act_lvl_i (act_lvl_i),
    .lvl_o     (lvl_w)
  );

  toc_state_reg u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_i     (chg_w),
    .chg_val_i (chg_val_w),
    .sw_wr_i   (sw_wr_i),
    .sw_val_i  (sw_val_i),
    .state_o   (st_w)
  );

  assign state_o = st_w;
  assign pin_o   = toc_pin_level(mode_w, st_w, lvl_w);
endmodule

// File: rtl/timer_out_ctrl_sva.sv
module timer_out_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic out_en_i,
  input logic sw_wr_i,
  input logic ev_toggle_i,
  input logic ev_set_i,
  input logic ev_reset_i,
  input logic set_fire_w,
  input logic chg_w,
  input logic state_o,
  input logic pin_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!state_o && !pin_o));

  p_toggle_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && out_en_i && ev_toggle_i) |=> (state_o != $past(state_o)));

  p_toggle_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |-> (pin_o == state_o));

  p_lazy_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && out_en_i && !chg_w && !sw_wr_i ##1 mode_i) |-> $stable(pin_o));

  // R4: the set lands one edge after the master pulse (default delay of one)
  p_set_delayed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && out_en_i && ev_set_i && !ev_reset_i ##1 mode_i && out_en_i && !ev_reset_i)
      |=> state_o);

  p_no_early_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && out_en_i && !set_fire_w && !sw_wr_i && !state_o) |=> !state_o);

  p_reset_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && out_en_i && ev_reset_i) |=> !state_o);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_i && !sw_wr_i) |=> $stable(state_o));
endmodule

bind timer_out_ctrl timer_out_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .out_en_i    (out_en_i),
  .sw_wr_i     (sw_wr_i),
  .ev_toggle_i (ev_toggle_i),
  .ev_set_i    (ev_set_i),
  .ev_reset_i  (ev_reset_i),
  .set_fire_w  (set_fire_w),
  .chg_w       (chg_w),
  .state_o     (state_o),
  .pin_o       (pin_o)
);

// File: tb/timer_out_ctrl_tb.sv
`timescale 1ns/1ps
module timer_out_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 0, act_lvl_i = 0, out_en_i = 0, sw_wr_i = 0, sw_val_i = 0;
  logic ev_toggle_i = 0, ev_set_i = 0, ev_reset_i = 0;
  logic state_o, pin_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  // behavioural reference
  bit m_state = 0;
  bit m_pol = 0;
  bit pend_q[$];

  always #5 clk = ~clk;

  timer_out_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .act_lvl_i(act_lvl_i),
    .out_en_i(out_en_i), .sw_wr_i(sw_wr_i), .sw_val_i(sw_val_i),
    .ev_toggle_i(ev_toggle_i), .ev_set_i(ev_set_i), .ev_reset_i(ev_reset_i),
    .state_o(state_o), .pin_o(pin_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit fire;
    bit changed;
    fire = pend_q.pop_front();
    pend_q.push_back(mode_i && ev_set_i);
    changed = 0;
    if (!rst_n) begin
      m_state = 0; m_pol = 0;
      pend_q.delete(); pend_q.push_back(1'b0);
      return;
    end
    if (out_en_i) begin
      if (mode_i) begin
        if (ev_reset_i)  begin m_state = 0; changed = 1; end
        else if (fire)   begin m_state = 1; changed = 1; end
      end else if (ev_toggle_i) begin
        m_state = !m_state; changed = 1;
      end
    end
    if (!out_en_i || changed) m_pol = act_lvl_i;
    if (!changed && sw_wr_i) m_state = sw_val_i;
  endtask

  task automatic step();
    bit exp_pin;
    @(posedge clk);
    #1;
    model_edge();
    exp_pin = mode_i ? (m_state ^ m_pol) : m_state;
    chk(state_o == m_state, "model state R2 R3", state_o, m_state);
    chk(pin_o == exp_pin, "model pin R3", pin_o, exp_pin);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    pend_q.push_back(1'b0);
    step(); step();
    chk(state_o == 0, "R1 state after reset", state_o, 0);
    chk(pin_o == 0, "R1 pin after reset", pin_o, 0);
    rst_n = 1;

    // R2 toggle mode, polarity ignored
    mode_i = 0; act_lvl_i = 1; out_en_i = 1;
    ev_toggle_i = 1; step();
    chk(state_o == 1, "R2 first toggle", state_o, 1);
    chk(pin_o == 1, "R2 pin equals state", pin_o, 1);
    step();
    chk(state_o == 0, "R2 second toggle", state_o, 0);
    ev_toggle_i = 0; ev_set_i = 1; ev_reset_i = 1; step();
    ev_set_i = 0; ev_reset_i = 0; step();
    chk(state_o == 0, "R2 set/reset ignored", state_o, 0);

    // R7 disabled: default level, events ignored
    act_lvl_i = 0; out_en_i = 0;
    sw_wr_i = 1; sw_val_i = 1; step();
    sw_wr_i = 0;
    chk(state_o == 1, "R7 default written", state_o, 1);
    ev_toggle_i = 1; step(); ev_toggle_i = 0;
    chk(state_o == 1, "R7 event ignored", state_o, 1);
    // R8 enable shows default, next toggle starts from it
    out_en_i = 1; step();
    chk(pin_o == 1, "R8 pin after enable", pin_o, 1);
    ev_toggle_i = 1; step(); ev_toggle_i = 0;
    chk(state_o == 0, "R8 toggle from default", state_o, 0);

    // R4 deferred set in combination mode
    mode_i = 1; step();
    ev_set_i = 1; step(); ev_set_i = 0;
    chk(state_o == 0, "R4 not yet set", state_o, 0);
    step();
    chk(state_o == 1, "R4 set after one clock", state_o, 1);
    chk(pin_o == 1, "R4 pin active high", pin_o, 1);

    // R3 lazy polarity
    act_lvl_i = 1; step(); step();
    chk(pin_o == 1, "R3 pin unchanged by polarity write", pin_o, 1);
    ev_reset_i = 1; step(); ev_reset_i = 0;
    chk(state_o == 0, "R3 reset state", state_o, 0);
    chk(pin_o == 1, "R3 new polarity applied", pin_o, 1);

    // R5 reset beats delayed set: 0 percent from low
    ev_set_i = 1; step(); ev_set_i = 0; ev_reset_i = 1; step(); ev_reset_i = 0;
    chk(state_o == 0, "R5 reset wins from low", state_o, 0);
    ev_set_i = 1; step(); ev_set_i = 0; step();
    chk(state_o == 1, "R5 set reached", state_o, 1);
    ev_set_i = 1; step(); ev_set_i = 0; ev_reset_i = 1; step(); ev_reset_i = 0;
    chk(state_o == 0, "R5 reset wins from high", state_o, 0);

    // R6 software write against event
    mode_i = 0; step();
    sw_wr_i = 1; sw_val_i = 0; ev_toggle_i = 1; step();
    sw_wr_i = 0; ev_toggle_i = 0;
    chk(state_o == 1, "R6 event beats write", state_o, 1);
    sw_wr_i = 1; sw_val_i = 0; step(); sw_wr_i = 0;
    chk(state_o == 0, "R6 write alone", state_o, 0);

    // R9 setting changes without events
    ev_toggle_i = 1; step(); ev_toggle_i = 0;
    mode_i = 1; act_lvl_i = 0; step();
    chk(state_o == 1, "R9 mode change holds state", state_o, 1);
    out_en_i = 0; act_lvl_i = 1; step();
    mode_i = 0; out_en_i = 1; step();
    chk(state_o == 1, "R9 enable/level change holds state", state_o, 1);

    // mixed random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      mode_i      = $urandom_range(0, 1);
      act_lvl_i   = ($urandom_range(0, 7) == 0) ? ~act_lvl_i : act_lvl_i;
      out_en_i    = ($urandom_range(0, 9) != 0);
      sw_wr_i     = ($urandom_range(0, 7) == 0);
      sw_val_i    = $urandom_range(0, 1);
      ev_toggle_i = ($urandom_range(0, 3) == 0);
      ev_set_i    = ($urandom_range(0, 3) == 0);
      ev_reset_i  = ($urandom_range(0, 4) == 0);
      rst_n       = ($urandom_range(0, 499) != 0);
      step();
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule